// File: doc/BRIEF.md
# UART Receive FIFO Interrupt Logic

This block buffers characters arriving from a UART receiver and raises the receive-side interrupts. Each character is a 12-bit word: 8 data bits and 4 error or status bits. Words go into a first-in first-out store of 32 entries. The host reads them from the front in arrival order. A receive-level interrupt reports that the fill level has reached a threshold chosen by software.

A level threshold leaves a gap. The last few characters of a burst can stop short of the threshold, and then no level interrupt is raised. A second source covers that case. It counts bit-period ticks while the store holds data and nothing arrives or is read. After 32 quiet bit periods it raises a receive-timeout interrupt. That interrupt stays up until the host drains the store or writes one to its clear bit.

A word that arrives while the store is full is dropped and sets a sticky overrun bit. A transmit request from elsewhere in the UART is carried as one more raw source. All four raw bits pass through a mask. The enabled bits are ORed into a single interrupt line.

Top module: `uart_rx_irq`

## Requirements
- R1: Words written with `rx_wr` are returned on `host_word` in arrival order. The store holds up to 32 words. `host_word` shows the oldest word while the store is not empty. A pulse of `host_rd` removes that word. A `host_rd` while the store is empty has no effect on `fill_level`.
- R2: Raw bit 1 (receive level) is 1 exactly when `fill_level` is at or above the threshold chosen by `level_sel`: 0→4, 1→8, 2→16, 3→24, 4→28. Values 5, 6 and 7 act as 0 (4 entries).
- R3: Raw bit 1 goes to 0 in the cycle after the read that brings `fill_level` below the threshold. Writes that leave the level below the threshold never set it.
- R4: Raw bit 2 (receive timeout) becomes 1 in the cycle after the 32nd `bit_tick`. Those ticks must come while the store is not empty and with no write or read since the count began. After 31 such ticks it is still 0. Ticks while the store is empty never set it.
- R5: A write pulse or a read pulse restarts the quiet count from zero.
- R6: Raw bit 2 goes to 0 in the cycle after the read that empties the store.
- R7: A `clr_strobe` with `clr_bits[2]` set drops raw bit 2 in the next cycle. It stays 0 until another write or read is followed by 32 quiet ticks. If the clear falls in the same cycle as the tick that completes the count, the bit is set.
- R8: A write while `fill_level` is 32 is dropped and leaves the store unchanged, even if a read falls in the same cycle. It sets raw bit 3 (overrun). Bit 3 stays set until a `clr_strobe` with `clr_bits[3]` set. A new overrun in the clear cycle keeps it set.
- R9: Raw bit 0 follows `tx_req`. A clear of bits 0 or 1 has no effect on them. `masked_status` = `raw_status & irq_mask`. `irq` is 1 exactly when `masked_status` is not zero.
- R10: After reset `fill_level` is 0, raw bits 1 to 3 are 0, and `irq` is 0 when `tx_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_wr | input | 1 | Received-word write strobe |
| rx_word | input | 12 | Received word: data and status bits |
| bit_tick | input | 1 | One pulse per serial bit period |
| host_rd | input | 1 | Host read pulse; removes the oldest word |
| host_word | output | 12 | Oldest stored word |
| level_sel | input | 3 | Receive-level threshold select |
| irq_mask | input | 4 | Enable bits: 0 transmit, 1 level, 2 timeout, 3 overrun |
| clr_strobe | input | 1 | Write strobe of the write-one-to-clear register |
| clr_bits | input | 4 | Bits to clear, same positions as the mask |
| tx_req | input | 1 | Raw transmit interrupt request |
| fill_level | output | 6 | Number of stored words |
| raw_status | output | 4 | Unmasked interrupt status |
| masked_status | output | 4 | Status ANDed with the mask |
| irq | output | 1 | Combined interrupt line |

## Verification
There are two same-cycle collisions to check. The first is the timeout clear arriving in the very cycle of the tick that completes the quiet count. The bench makes this happen by issuing the clear on the 32nd tick. It expects the timeout bit to be set in the following cycle, and a later clear alone to drop it. The second is an overrun clear meeting a new write to the full store, which must leave the overrun bit set. A full-store write with a read in the same cycle is also driven, and the bench expects the word to be dropped and the count to fall by one.

// File: rtl/uart_rx_irq_pkg.sv
package uart_rx_irq_pkg;
  localparam int IRQ_W    = 4;
  localparam int IRQ_TX   = 0;
  localparam int IRQ_LVL  = 1;
  localparam int IRQ_TOUT = 2;
  localparam int IRQ_OVR  = 3;

  // threshold in entries for a select code; eighths 1,2,4,6,7, others as code 0
  function automatic int level_threshold(input logic [2:0] sel, input int depth);
    case (sel)
      3'd1:    return (depth / 8) * 2;
      3'd2:    return (depth / 8) * 4;
      3'd3:    return (depth / 8) * 6;
      3'd4:    return (depth / 8) * 7;
      default: return depth / 8;
    endcase
  endfunction
endpackage

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 12,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    fill,
  output logic             empty,
  output logic             full,
  output logic             push_ok,
  output logic             pop_ok
);
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [WIDTH-1:0] mem [DEPTH];

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = wr && !full;
  assign pop_ok  = rd && !empty;
  assign fill    = cnt_q;
  assign rd_data = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    if (push_ok) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop_ok)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= wr_data;
  end

  // R1
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr && !rd) |=> (fill == CW'(DEPTH)));
  // R1
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd && !wr) |=> (fill == '0));
endmodule

// File: rtl/rx_timeout.sv
module rx_timeout #(
  parameter int LIMIT = 32,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic activity,
  input  logic empty,
  input  logic clr,
  output logic timeout
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          expire;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (activity || empty) begin
      cnt_d = '0;
    end else if (bit_tick && (cnt_q != TW'(LIMIT))) begin
      cnt_d  = cnt_q + 1'b1;
      expire = (cnt_q == TW'(LIMIT - 1));
    end
    flag_d = flag_q;
    if (empty || clr) flag_d = 1'b0;
    if (expire)       flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign timeout = flag_q && !empty;

  // R4
  tick_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $past(bit_tick && !activity));
  // R6
  empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !timeout);
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !bit_tick) |=> !timeout);
endmodule

// File: rtl/irq_status.sv
module irq_status
  import uart_rx_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_req,
  input  logic             level_hit,
  input  logic             timeout,
  input  logic             overrun_evt,
  input  logic             clr_strobe,
  input  logic [IRQ_W-1:0] clr_bits,
  input  logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] raw,
  output logic [IRQ_W-1:0] masked,
  output logic             irq
);
  logic ovr_q, ovr_d;
  logic ovr_clr;

  assign ovr_clr = clr_strobe && clr_bits[IRQ_OVR];

  always_comb begin
    ovr_d = (ovr_q && !ovr_clr) || overrun_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  always_comb begin
    raw           = '0;
    raw[IRQ_TX]   = tx_req;
    raw[IRQ_LVL]  = level_hit;
    raw[IRQ_TOUT] = timeout;
    raw[IRQ_OVR]  = ovr_q;
  end

  for (genvar i = 0; i < IRQ_W; i++) begin : g_mask
    assign masked[i] = raw[i] & mask[i];
  end

  assign irq = |masked;

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[IRQ_OVR] && !ovr_clr) |=> raw[IRQ_OVR]);
  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> raw[IRQ_OVR]);
endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq
  import uart_rx_irq_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int WIDTH   = 12,
  parameter int QUIET   = 32,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_wr,
  input  logic [WIDTH-1:0] rx_word,
  input  logic             bit_tick,
  input  logic             host_rd,
  output logic [WIDTH-1:0] host_word,
  input  logic [2:0]       level_sel,
  input  logic [IRQ_W-1:0] irq_mask,
  input  logic             clr_strobe,
  input  logic [IRQ_W-1:0] clr_bits,
  input  logic             tx_req,
  output logic [CW-1:0]    fill_level,
  output logic [IRQ_W-1:0] raw_status,
  output logic [IRQ_W-1:0] masked_status,
  output logic             irq
);
  logic empty, full, push_ok, pop_ok;
  logic level_hit, timeout;

  rx_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(rx_wr), .wr_data(rx_word), .rd(host_rd),
    .rd_data(host_word), .fill(fill_level), .empty(empty), .full(full),
    .push_ok(push_ok), .pop_ok(pop_ok)
  );

  assign level_hit = (int'(fill_level) >= level_threshold(level_sel, DEPTH));

  rx_timeout #(.LIMIT(QUIET)) u_tout (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .activity(rx_wr || host_rd),
    .empty(empty), .clr(clr_strobe && clr_bits[IRQ_TOUT]), .timeout(timeout)
  );

  irq_status u_stat (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .level_hit(level_hit),
    .timeout(timeout), .overrun_evt(rx_wr && full), .clr_strobe(clr_strobe),
    .clr_bits(clr_bits), .mask(irq_mask), .raw(raw_status),
    .masked(masked_status), .irq(irq)
  );

  // R9
  irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (masked_status != '0));
  // R2
  level_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level < CW'(DEPTH / 8)) |-> !raw_status[IRQ_LVL]);
endmodule

// File: tb/uart_rx_irq_test.sv
module uart_rx_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_wr = 1'b0;
  logic [11:0] rx_word = '0;
  logic        bit_tick = 1'b0;
  logic        host_rd = 1'b0;
  logic [11:0] host_word;
  logic [2:0]  level_sel = '0;
  logic [3:0]  irq_mask = '0;
  logic        clr_strobe = 1'b0;
  logic [3:0]  clr_bits = '0;
  logic        tx_req = 1'b0;
  logic [5:0]  fill_level;
  logic [3:0]  raw_status, masked_status;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  uart_rx_irq uut (
    .clk(clk), .rst_n(rst_n), .rx_wr(rx_wr), .rx_word(rx_word), .bit_tick(bit_tick),
    .host_rd(host_rd), .host_word(host_word), .level_sel(level_sel),
    .irq_mask(irq_mask), .clr_strobe(clr_strobe), .clr_bits(clr_bits),
    .tx_req(tx_req), .fill_level(fill_level), .raw_status(raw_status),
    .masked_status(masked_status), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic int thr(input int sel);
    case (sel)
      1: return 8;
      2: return 16;
      3: return 24;
      4: return 28;
      default: return 4;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit w, input logic [11:0] wd, input bit r, input bit t,
                       input bit c, input logic [3:0] cb);
    @(negedge clk);
    rx_wr = w; rx_word = wd; host_rd = r; bit_tick = t; clr_strobe = c; clr_bits = cb;
    @(posedge clk);
    #2;
    rx_wr = 0; host_rd = 0; bit_tick = 0; clr_strobe = 0; clr_bits = '0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) drive(0, '0, 0, 1, 0, '0);
  endtask

  task automatic drain();
    while (fill_level != 0) drive(0, '0, 1, 0, 0, '0);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    irq_mask = 4'hF;
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    check("R10 fill", fill_level, 0);
    check("R10 raw", raw_status, 0);
    check("R10 irq", irq, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R1 R8: sweep every threshold code, fill to full, overflow, drain
    for (int sel = 0; sel < 8; sel++) begin
      level_sel = 3'(sel);
      for (int i = 0; i < 32; i++) begin
        drive(1, 12'((sel << 8) | (i * 7)), 0, 0, 0, '0);
        check("R1 fill up", fill_level, i + 1);
        check("R2 level up", raw_status[1], (i + 1) >= thr(sel));
      end
      drive(1, 12'hFFF, 0, 0, 0, '0);
      check("R8 dropped fill", fill_level, 32);
      check("R8 overrun set", raw_status[3], 1);
      drive(1, 12'hEEE, 0, 0, 1, 4'b1000);
      check("R8 set wins over clear", raw_status[3], 1);
      drive(0, '0, 0, 0, 1, 4'b1000);
      check("R8 overrun cleared", raw_status[3], 0);
      for (int i = 0; i < 32; i++) begin
        check("R1 order", host_word, 12'((sel << 8) | (i * 7)));
        drive(0, '0, 1, 0, 0, '0);
        check("R3 level down", raw_status[1], (31 - i) >= thr(sel));
      end
      check("R1 empty", fill_level, 0);
    end
    drive(0, '0, 1, 0, 0, '0);
    check("R1 read on empty", fill_level, 0);

    // R8 full store with read in same cycle: write dropped, count drops
    for (int i = 0; i < 32; i++) drive(1, 12'(i), 0, 0, 0, '0);
    drive(1, 12'h5A5, 1, 0, 0, '0);
    check("R8 full write with read", fill_level, 31);
    for (int i = 1; i < 32; i++) begin
      check("R8 no corrupt", host_word, i);
      drive(0, '0, 1, 0, 0, '0);
    end
    drive(0, '0, 0, 0, 1, 4'b1000);

    // R4 ticks while empty do nothing
    level_sel = 3'd4;
    ticks(40);
    check("R4 empty ticks", raw_status[2], 0);

    // R4 31 vs 32 ticks below threshold
    for (int n = 1; n <= 3; n++) begin
      for (int i = 0; i < n; i++) drive(1, 12'(i), 0, 0, 0, '0);
      check("R2 below threshold", raw_status[1], 0);
      ticks(31);
      check("R4 before limit", raw_status[2], 0);
      ticks(1);
      check("R4 at limit", raw_status[2], 1);
      check("R9 masked timeout", masked_status[2], 1);
      check("R9 irq timeout", irq, 1);
      // R6 reads that do not empty keep it, empty drops it
      for (int i = 0; i < n - 1; i++) begin
        drive(0, '0, 1, 0, 0, '0);
        check("R6 partial read", raw_status[2], 1);
      end
      drive(0, '0, 1, 0, 0, '0);
      check("R6 drained", raw_status[2], 0);
    end

    // R5 write and read restart the count
    drive(1, 12'h11, 0, 0, 0, '0);
    drive(1, 12'h22, 0, 0, 0, '0);
    ticks(20);
    drive(1, 12'h33, 0, 0, 0, '0);
    ticks(31);
    check("R5 write restart", raw_status[2], 0);
    drive(0, '0, 1, 0, 0, '0);
    ticks(31);
    check("R5 read restart", raw_status[2], 0);
    ticks(1);
    check("R5 after restart", raw_status[2], 1);

    // R7 clear, stays clear, re-arms after activity
    drive(0, '0, 0, 0, 1, 4'b0100);
    check("R7 cleared", raw_status[2], 0);
    ticks(40);
    check("R7 stays clear", raw_status[2], 0);
    drive(1, 12'h44, 0, 0, 0, '0);
    ticks(31);
    drive(0, '0, 0, 1, 1, 4'b0100);
    check("R7 set wins over clear", raw_status[2], 1);
    drive(0, '0, 0, 0, 1, 4'b0100);
    check("R7 clear alone", raw_status[2], 0);
    drain();

    // R9 mask, transmit passthrough, clears of level sources ignored
    for (int m = 0; m < 16; m++) begin
      irq_mask = 4'(m);
      tx_req = 1'b1;
      level_sel = 3'd0;
      for (int i = 0; i < 4; i++) drive(1, 12'(i), 0, 0, 0, '0);
      drive(0, '0, 0, 0, 1, 4'b0011);
      check("R9 tx raw", raw_status[0], 1);
      check("R9 level kept", raw_status[1], 1);
      check("R9 masked", masked_status, 4'b0011 & 4'(m));
      check("R9 irq", irq, (m & 3) != 0);
      tx_req = 1'b0;
      drain();
      #1;
      check("R9 irq low", irq, 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule